// File: doc/BRIEF.md
# Multi-Block Erase Scheduler

This block sequences block erases inside a parallel NOR-flash model. A command decoder sends it block-select strobes, each carrying a block index. The first strobe opens a collection window. Each further strobe adds its block to the list and restarts the window. When the window runs out, the scheduler starts erasing the listed blocks one at a time, lowest index first. A timing counter outside this block reports each finished block with a done pulse, or a failure with a fail pulse.

Blocks marked in the protection map are dropped from the list without any error. If every selected block is protected, the scheduler stays busy for a fixed idle period and then returns to idle with nothing erased. A suspend request behaves in one of two ways. Before erasing has begun, it takes effect at once, and the later resume starts erasing immediately with the list frozen. After erasing has begun, the suspended state appears only after a halt latency. A reset request clears a collection at once. Once erasing has begun, a reset request instead runs an abort period, which also clears a pending error. All delays are parameters counted in clock cycles.

Top module: `erase_sched`

## Requirements
- R1: A select strobe with index i (bit i of every block vector, i below NUM_BLK) adds block i to `erase_set` on the next cycle, unless its `prot_map` bit is 1. Any strobe while idle opens the window and raises `busy`.
- R2: `started` rises exactly WIN_CYC cycles after the most recent accepted select strobe, so every added block restarts the window.
- R3: Once `started` is high, select strobes change nothing: `erase_set` only loses bits.
- R4: While erasing, `cur_blk` is the lowest index set in `erase_set` and `erase_run` is high. A `blk_done` pulse clears that bit. When the last bit clears, `busy` is low on the next cycle.
- R5: A suspend request while erasing drops `erase_run` on the next cycle. `suspended` rises exactly SUSP_CYC cycles after the request. A resume request brings `erase_run` back on the next cycle with `suspended` low. This can be repeated any number of times.
- R6: A suspend request during the window raises `suspended` on the next cycle with `started` low. Select strobes are then ignored. A resume request raises `started` and `erase_run` on the next cycle.
- R7: Protected blocks never appear in `erase_set`. If all selected blocks are protected, `started` rises as usual, `busy` stays high for EMPTY_CYC cycles, and then the scheduler goes idle with `error` low.
- R8: A reset request once `started` is high sets `aborting` on the next cycle, with `error` low and `erase_set` empty. `aborting` lasts ABORT_CYC cycles, and then `busy` is low. A reset request during the window clears everything on the next cycle.
- R9: A `blk_fail` pulse while erasing sets `error` and marks the current block in `fault_set`. `busy` stays high and `erase_run` low until a reset request.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_vld | input | 1 | Block-select strobe |
| sel_idx | input | IW | Index of the selected block |
| susp_req | input | 1 | Suspend request |
| resume_req | input | 1 | Resume request |
| reset_req | input | 1 | Abort / clear-error request |
| prot_map | input | NUM_BLK | Per-block protection bits |
| blk_done | input | 1 | Current block finished erasing |
| blk_fail | input | 1 | Current block failed to erase |
| erase_set | output | NUM_BLK | Blocks still to erase |
| fault_set | output | NUM_BLK | Blocks that failed |
| cur_blk | output | IW | Block now being erased |
| erase_run | output | 1 | Erase timing counter enable |
| started | output | 1 | Window closed, operation under way |
| busy | output | 1 | Any activity |
| suspended | output | 1 | Operation suspended |
| error | output | 1 | Erase failure pending |
| aborting | output | 1 | Abort period in progress |

## Verification
A table of select/protect mask pairs is run through the scheduler. The pairs cover a single block, a sparse list with one protected member, a full list with both edge blocks protected, a list in which every block is protected, and a top-edge block on its own. Together they separate correct ascending order from other orders, show that masking happens at selection time, and distinguish the empty-list path from a normal erase. Directed sequences then compare suspend before and after the start, test restarting the window against a fixed window, and contrast an abort during the window with an abort once erasing has begun, as well as the failure hold.

// File: rtl/esched_pkg.sv
package esched_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_PRE_SUSP,
        ST_ERASE,
        ST_HALTING,
        ST_SUSP,
        ST_EMPTY,
        ST_FAILED,
        ST_ABORT
    } sched_st_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic is_started(input sched_st_e s);
        return (s == ST_ERASE) || (s == ST_HALTING) || (s == ST_SUSP) ||
               (s == ST_EMPTY) || (s == ST_FAILED)  || (s == ST_ABORT);
    endfunction

endpackage

// File: rtl/esched_delay.sv
module esched_delay #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [CW-1:0] lim,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    assign expire = (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst || clr)   cnt_q <= '0;
        else if (!expire) cnt_q <= cnt_q + 1'b1;
    end

    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        !clr && !$past(clr) && $past(expire) |-> $stable(cnt_q));
endmodule

// File: rtl/esched_pick.sv
module esched_pick #(
    parameter int NB = 7,
    parameter int IW = 3
) (
    input  logic [NB-1:0] vec,
    output logic [IW-1:0] idx,
    output logic [NB-1:0] oh
);
    always_comb begin
        idx = '0;
        oh  = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
                oh  = NB'(1) << i;
            end
        end
    end

    always_comb begin
        a_r4_pick_onehot: assert ($onehot0(oh));
    end
endmodule

// File: rtl/erase_sched.sv
module erase_sched
    import esched_pkg::*;
#(
    parameter int NUM_BLK   = 7,
    parameter int WIN_CYC   = 12,
    parameter int SUSP_CYC  = 4,
    parameter int EMPTY_CYC = 8,
    parameter int ABORT_CYC = 3,
    localparam int IW = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_vld,
    input  logic [IW-1:0]      sel_idx,
    input  logic               susp_req,
    input  logic               resume_req,
    input  logic               reset_req,
    input  logic [NUM_BLK-1:0] prot_map,
    input  logic               blk_done,
    input  logic               blk_fail,
    output logic [NUM_BLK-1:0] erase_set,
    output logic [NUM_BLK-1:0] fault_set,
    output logic [IW-1:0]      cur_blk,
    output logic               erase_run,
    output logic               started,
    output logic               busy,
    output logic               suspended,
    output logic               error,
    output logic               aborting
);
    localparam int MAXD = max2(max2(WIN_CYC, SUSP_CYC), max2(EMPTY_CYC, ABORT_CYC));
    localparam int CW   = $clog2(MAXD + 1);

    sched_st_e          st_q, st_d;
    logic [NUM_BLK-1:0] pend_q, pend_d, fault_q, fault_d, cur_oh, sel_bit;
    logic               err_q, err_d, add_sel, expire, cnt_clr;
    logic [CW-1:0]      lim;

    assign sel_bit = (NUM_BLK'(1) << sel_idx) & ~prot_map;

    esched_pick #(.NB(NUM_BLK), .IW(IW)) pick_i (
        .vec(pend_q), .idx(cur_blk), .oh(cur_oh)
    );

    always_comb begin
        case (st_q)
            ST_COLLECT: lim = CW'(WIN_CYC - 1);
            ST_HALTING: lim = CW'(SUSP_CYC - 1);
            ST_EMPTY:   lim = CW'(EMPTY_CYC - 1);
            ST_ABORT:   lim = CW'(ABORT_CYC - 1);
            default:    lim = '0;
        endcase
    end

    assign cnt_clr = (st_d != st_q) || add_sel;

    esched_delay #(.CW(CW)) dly_i (
        .clk(clk), .rst(rst), .clr(cnt_clr), .lim(lim), .expire(expire)
    );

    always_comb begin
        st_d    = st_q;
        pend_d  = pend_q;
        fault_d = fault_q;
        err_d   = err_q;
        add_sel = 1'b0;
        if (reset_req && is_started(st_q) && st_q != ST_ABORT) begin
            st_d   = ST_ABORT;
            pend_d = '0;
            err_d  = 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (sel_vld) begin
                    st_d    = ST_COLLECT;
                    pend_d  = sel_bit;
                    fault_d = '0;
                    add_sel = 1'b1;
                end
                ST_COLLECT: begin
                    if (reset_req) begin
                        st_d   = ST_IDLE;
                        pend_d = '0;
                    end else if (susp_req) begin
                        st_d = ST_PRE_SUSP;
                    end else if (sel_vld) begin
                        pend_d  = pend_q | sel_bit;
                        add_sel = 1'b1;
                    end else if (expire) begin
                        st_d = (pend_q == '0) ? ST_EMPTY : ST_ERASE;
                    end
                end
                ST_PRE_SUSP: begin
                    if (reset_req) begin
                        st_d   = ST_IDLE;
                        pend_d = '0;
                    end else if (resume_req) begin
                        st_d = (pend_q == '0) ? ST_EMPTY : ST_ERASE;
                    end
                end
                ST_ERASE: begin
                    if (blk_fail) begin
                        fault_d = fault_q | cur_oh;
                        err_d   = 1'b1;
                        st_d    = ST_FAILED;
                    end else if (blk_done) begin
                        pend_d = pend_q & ~cur_oh;
                        if ((pend_q & ~cur_oh) == '0) st_d = ST_IDLE;
                    end else if (susp_req) begin
                        st_d = ST_HALTING;
                    end
                end
                ST_HALTING: if (expire)     st_d = ST_SUSP;
                ST_SUSP:    if (resume_req) st_d = ST_ERASE;
                ST_EMPTY:   if (expire)     st_d = ST_IDLE;
                ST_ABORT:   if (expire)     st_d = ST_IDLE;
                default:    st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            pend_q  <= '0;
            fault_q <= '0;
            err_q   <= 1'b0;
        end else begin
            st_q    <= st_d;
            pend_q  <= pend_d;
            fault_q <= fault_d;
            err_q   <= err_d;
        end
    end

    assign erase_set = pend_q;
    assign fault_set = fault_q;
    assign erase_run = (st_q == ST_ERASE);
    assign started   = is_started(st_q);
    assign busy      = (st_q != ST_IDLE);
    assign suspended = (st_q == ST_PRE_SUSP) || (st_q == ST_SUSP);
    assign error     = err_q;
    assign aborting  = (st_q == ST_ABORT);

    a_r3_list_frozen: assert property (@(posedge clk) disable iff (rst)
        started && $past(started) |-> (erase_set & ~$past(erase_set)) == '0);
    a_r4_cur_pending: assert property (@(posedge clk) disable iff (rst)
        erase_run |-> erase_set[cur_blk]);
    a_r5_halt_latency: assert property (@(posedge clk) disable iff (rst)
        erase_run && susp_req |=> !suspended);
    a_r6_pre_hold: assert property (@(posedge clk) disable iff (rst)
        suspended && !started && !resume_req && !reset_req |=> suspended && !started);
    a_r7_no_protected: assert property (@(posedge clk) disable iff (rst)
        started && $stable(prot_map) |-> (erase_set & prot_map) == '0);
    a_r8_abort_clean: assert property (@(posedge clk) disable iff (rst)
        aborting |-> !error && erase_set == '0);
    a_r9_error_holds: assert property (@(posedge clk) disable iff (rst)
        error |-> busy && !erase_run);
endmodule

// File: tb/erase_sched_tb_top.sv
module erase_sched_tb_top;
    localparam int NB = 7, W = 12, SC = 4, EC = 8, AC = 3, IW = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic sel_vld = 0, susp_req = 0, resume_req = 0, reset_req = 0;
    logic blk_done = 0, blk_fail = 0;
    logic [IW-1:0] sel_idx = '0;
    logic [NB-1:0] prot_map = '0;
    logic [NB-1:0] erase_set, fault_set;
    logic [IW-1:0] cur_blk;
    logic erase_run, started, busy, suspended, error, aborting;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    erase_sched #(.NUM_BLK(NB), .WIN_CYC(W), .SUSP_CYC(SC), .EMPTY_CYC(EC),
                  .ABORT_CYC(AC)) dut_i (
        .clk(clk), .rst(rst), .sel_vld(sel_vld), .sel_idx(sel_idx),
        .susp_req(susp_req), .resume_req(resume_req), .reset_req(reset_req),
        .prot_map(prot_map), .blk_done(blk_done), .blk_fail(blk_fail),
        .erase_set(erase_set), .fault_set(fault_set), .cur_blk(cur_blk),
        .erase_run(erase_run), .started(started), .busy(busy),
        .suspended(suspended), .error(error), .aborting(aborting)
    );

    // {select mask, protect mask}
    localparam logic [13:0] VEC [5] = '{
        {7'b0000001, 7'b0000000},
        {7'b1010101, 7'b0000100},
        {7'b1111111, 7'b1000001},
        {7'b0100110, 7'b0100110},
        {7'b1000000, 7'b0111111}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sel(input int i);
        sel_vld = 1; sel_idx = IW'(i); tick(); sel_vld = 0;
    endtask
    task automatic pulse_susp();   susp_req = 1;   tick(); susp_req = 0;   endtask
    task automatic pulse_resume(); resume_req = 1; tick(); resume_req = 0; endtask
    task automatic pulse_reset();  reset_req = 1;  tick(); reset_req = 0;  endtask
    task automatic pulse_done();   blk_done = 1;   tick(); blk_done = 0;   endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        // R10: reset state
        chk({erase_set, fault_set, started, busy, suspended, error, aborting, erase_run} == '0,
            "R10 reset state", busy, 0);

        // Vector table: R1, R2, R4, R7
        for (int v = 0; v < 5; v++) begin
            logic [NB-1:0] s, p, e;
            bit early;
            s = VEC[v][13:7]; p = VEC[v][6:0]; e = s & ~p;
            prot_map = p;
            for (int i = 0; i < NB; i++) if (s[i]) sel(i);
            chk(busy && erase_set == e, "R1 collected set", erase_set, e);
            early = 0;
            for (int k = 0; k < W - 1; k++) begin tick(); if (started) early = 1; end
            chk(!early, "R2 no early start", early, 0);
            tick();
            chk(started, "R2 start after window", started, 1);
            chk(erase_set == e && (erase_set & p) == 0, "R7 protected dropped", erase_set, e);
            if (e == 0) begin
                for (int k = 0; k < EC - 1; k++) tick();
                chk(busy && !error, "R7 empty busy hold", busy, 1);
                tick();
                chk(!busy && !error, "R7 empty ends idle", busy, 0);
            end else begin
                for (int b = 0; b < NB; b++) if (e[b]) begin
                    chk(erase_run && cur_blk == IW'(b), "R4 ascending order", cur_blk, b);
                    pulse_done();
                end
                chk(!busy && erase_set == 0, "R4 idle after last", busy, 0);
            end
        end
        prot_map = '0;

        // R2 restart + R3 frozen list + R5 repeated suspend + R8 abort
        sel(1);
        repeat (W - 3) tick();
        sel(4);
        repeat (W - 1) tick();
        chk(!started, "R2 window restarted", started, 0);
        tick();
        chk(started && erase_set == 7'b0010010, "R2 start after restart", erase_set, 7'h12);
        sel(0);
        chk(erase_set == 7'b0010010, "R3 select after start ignored", erase_set, 7'h12);
        for (int r = 0; r < 2; r++) begin
            pulse_susp();
            chk(!suspended && !erase_run, "R5 halt in progress", suspended, 0);
            repeat (SC - 1) tick();
            chk(!suspended, "R5 not before latency", suspended, 0);
            tick();
            chk(suspended && !erase_run, "R5 suspended at latency", suspended, 1);
            pulse_resume();
            chk(!suspended && erase_run && cur_blk == 1, "R5 resumed", cur_blk, 1);
        end
        pulse_reset();
        chk(aborting && !error && erase_set == 0, "R8 abort entered", aborting, 1);
        repeat (AC - 1) tick();
        chk(aborting, "R8 abort held", aborting, 1);
        tick();
        chk(!busy && !aborting, "R8 abort done", busy, 0);

        // R6 pre-start suspend, then R9 failure
        sel(2); sel(5);
        pulse_susp();
        chk(suspended && !started, "R6 immediate suspend", suspended, 1);
        sel(6);
        chk(erase_set == 7'b0100100, "R6 select ignored while suspended", erase_set, 7'h24);
        pulse_resume();
        chk(started && erase_run && cur_blk == 2, "R6 resume starts at once", cur_blk, 2);
        blk_fail = 1; tick(); blk_fail = 0;
        chk(error && fault_set == 7'b0000100 && busy && !erase_run, "R9 fail latched",
            fault_set, 7'h04);
        repeat (5) tick();
        chk(error && busy, "R9 held until reset", error, 1);
        pulse_reset();
        chk(!error && aborting, "R8 reset clears error", error, 0);
        repeat (AC) tick();
        chk(!busy, "R8 idle after abort", busy, 0);

        // R8 reset during the window
        sel(3);
        pulse_reset();
        chk(!busy && erase_set == 0 && !aborting, "R8 window cleared", busy, 0);

        summary();
    end
endmodule